// File: doc/BRIEF.md
# Demand-Driven Clock Source Controller

This block governs one clock source of a small configurable logic fabric. It decides, cycle by cycle, whether the free-running oscillator is enabled. Either the oscillator is held on permanently, or it wakes only while one of the attached delay blocks holds a request line high. A level on a power-down pin can override both of these, but only when that pin is allowed to act.

The source clock is either the oscillator or an external clock input. It is chosen before any division. A predivider drives the peripheral clock, and a second divider fed from the predivider drives the clock that goes to the routing fabric. That fabric clock can be gated to a constant LOW. While the oscillator is disabled, both divider chains are cleared and both clock outputs stay LOW.

The oscillator and external clocks arrive as levels that are sampled on the fast block clock `clk`. All state lives in that single domain. A delay block raises its request when its input changes and drops the request when its delay completes. The oscillator therefore wakes once for a rising-edge delay and again for a falling-edge delay, and it sleeps in between. Counter-mode blocks raise no request, so they need the forced mode.

Top module: `clk_source_ctrl`

## Requirements
- R1: When `pd_en` is 1 and `pwr_down` is 1, `osc_en` is 0 one cycle later. This overrides `force_on` and all requests.
- R2: When `pd_en` is 0, the `pwr_down` level has no effect. `osc_en` follows `force_on` and the requests one cycle later.
- R3: With `force_on` at 1 and no active power-down, `osc_en` is 1 one cycle later.
- R4: With no force and no active power-down, `osc_en` is 1 one cycle after any bit of `dly_req` is 1. It stays 1 until every bit has returned to 0.
- R5: With no force and no requests, `osc_en` is 0 one cycle later. A later request wakes it again, so each delay edge gets its own wake period.
- R6: `sel_ext`=0 feeds `osc_clk` into the dividers, and `sel_ext`=1 feeds `ext_clk`.
- R7: `pre_sel` values 0, 1, 2, 3 divide the selected source by 1, 2, 4, 8, giving `periph_clk`. For a ratio N≥2, counting source rising edges from 1, the output goes HIGH on each edge whose count is a multiple of N. It goes LOW on the edge whose count modulo N equals N/2, rounded down. At ratio 1 the output is the source level delayed by one cycle.
- R8: `sec_sel` values 0–7 divide `periph_clk` by 1, 2, 3, 4, 8, 12, 24, 64, with the same waveform rule as R7. The result is the second-divider clock behind `matrix_clk`.
- R9: When `mtx_en` is 0, `matrix_clk` is LOW. When it is 1, `matrix_clk` carries the second-divider clock.
- R10: In the cycle after `osc_en` is 0, `periph_clk` and `matrix_clk` are 0 and all divider counts are cleared. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Raw oscillator level |
| ext_clk | input | 1 | External clock level |
| pwr_down | input | 1 | Power-down pin, HIGH requests off |
| pd_en | input | 1 | Allows `pwr_down` to act |
| force_on | input | 1 | Keep oscillator running |
| sel_ext | input | 1 | Source select: 0 oscillator, 1 external |
| mtx_en | input | 1 | Gate for `matrix_clk` |
| pre_sel | input | 2 | Predivider ratio code |
| sec_sel | input | 3 | Second divider ratio code |
| dly_req | input | NREQ | Wake requests from delay blocks |
| osc_en | output | 1 | Oscillator enable |
| matrix_clk | output | 1 | Gated, twice-divided clock to fabric |
| periph_clk | output | 1 | Predivided clock to peripherals |

## Verification
`osc_en` is due one cycle after the power-down, force or request inputs change. `periph_clk` follows a sampled source edge in the next cycle. The second divider adds one more cycle for its own edge detect, so `matrix_clk` is due two cycles after the source edge. All inputs change on the falling edge, and the outputs are compared on the following falling edge against a behavioural model that steps once per rising edge. Each result is therefore judged exactly one edge after the stimulus it depends on. Separate edge-count windows confirm each divider's period within one edge.

// File: rtl/clk_source_ctrl.sv
module clk_source_ctrl #(
  parameter int NREQ = 4,
  parameter int PRE_MAX = 8,
  parameter int SEC_MAX = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_clk,
  input  logic            ext_clk,
  input  logic            pwr_down,
  input  logic            pd_en,
  input  logic            force_on,
  input  logic            sel_ext,
  input  logic            mtx_en,
  input  logic [1:0]      pre_sel,
  input  logic [2:0]      sec_sel,
  input  logic [NREQ-1:0] dly_req,
  output logic            osc_en,
  output logic            matrix_clk,
  output logic            periph_clk
);
  localparam int PRE_W = $clog2(PRE_MAX);
  localparam int SEC_W = $clog2(SEC_MAX);

  logic             pd_act, want_on;
  logic             src, src_d, src_rise;
  logic [PRE_W:0]   pre_n;
  logic [PRE_W-1:0] pre_cnt, pre_nxt;
  logic [SEC_W:0]   sec_n;
  logic [SEC_W-1:0] sec_cnt, sec_nxt;
  logic             pre_d, pre_rise, sec_out;

  assign pd_act  = pd_en & pwr_down;
  assign want_on = force_on | (|dly_req);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) osc_en <= 1'b0;
    else        osc_en <= ~pd_act & want_on;

  assign src      = sel_ext ? ext_clk : osc_clk;
  assign src_rise = src & ~src_d;
  assign pre_n    = (PRE_W+1)'(1) << pre_sel;
  assign pre_nxt  = ({1'b0, pre_cnt} >= pre_n - 1'b1) ? '0 : pre_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_d <= 1'b0; pre_cnt <= '0; periph_clk <= 1'b0;
    end else if (!osc_en) begin
      src_d <= 1'b0; pre_cnt <= '0; periph_clk <= 1'b0;
    end else begin
      src_d <= src;
      if (pre_n == 1) periph_clk <= src;
      else if (src_rise) begin
        pre_cnt <= pre_nxt;
        if (pre_nxt == '0)                       periph_clk <= 1'b1;
        else if ({1'b0, pre_nxt} == (pre_n >> 1)) periph_clk <= 1'b0;
      end
    end

  always_comb
    case (sec_sel)
      3'd0:    sec_n = (SEC_W+1)'(1);
      3'd1:    sec_n = (SEC_W+1)'(2);
      3'd2:    sec_n = (SEC_W+1)'(3);
      3'd3:    sec_n = (SEC_W+1)'(4);
      3'd4:    sec_n = (SEC_W+1)'(8);
      3'd5:    sec_n = (SEC_W+1)'(12);
      3'd6:    sec_n = (SEC_W+1)'(24);
      default: sec_n = (SEC_W+1)'(SEC_MAX);
    endcase

  assign pre_rise = periph_clk & ~pre_d;
  assign sec_nxt  = ({1'b0, sec_cnt} >= sec_n - 1'b1) ? '0 : sec_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_d <= 1'b0; sec_cnt <= '0; sec_out <= 1'b0;
    end else if (!osc_en) begin
      pre_d <= 1'b0; sec_cnt <= '0; sec_out <= 1'b0;
    end else begin
      pre_d <= periph_clk;
      if (sec_n == 1) sec_out <= periph_clk;
      else if (pre_rise) begin
        sec_cnt <= sec_nxt;
        if (sec_nxt == '0)                       sec_out <= 1'b1;
        else if ({1'b0, sec_nxt} == (sec_n >> 1)) sec_out <= 1'b0;
      end
    end

  assign matrix_clk = sec_out & mtx_en;
endmodule

// File: rtl/clk_source_ctrl_chk.sv
module clk_source_ctrl_chk #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwr_down,
  input logic            pd_en,
  input logic            force_on,
  input logic [NREQ-1:0] dly_req,
  input logic            osc_en,
  input logic            matrix_clk,
  input logic            periph_clk
);
  AST_PD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en && pwr_down) |=> !osc_en); // R1
  AST_PD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_en && (force_on || dly_req != '0)) |=> osc_en); // R2
  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pd_en && pwr_down) && force_on) |=> osc_en); // R3
  AST_REQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pd_en && pwr_down) && dly_req != '0) |=> osc_en); // R4
  AST_IDLE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_on && dly_req == '0) |=> !osc_en); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (!periph_clk && !matrix_clk)); // R10
endmodule

bind clk_source_ctrl clk_source_ctrl_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .pd_en(pd_en),
  .force_on(force_on), .dly_req(dly_req), .osc_en(osc_en),
  .matrix_clk(matrix_clk), .periph_clk(periph_clk)
);

// File: tb/clk_source_ctrl_test.sv
`timescale 1ns/1ps
module clk_source_ctrl_test;
  localparam int NREQ = 4;

  logic clk = 0, rst_n = 0;
  logic osc_clk = 0, ext_clk = 0, pwr_down = 0, pd_en = 0, force_on = 0;
  logic sel_ext = 0, mtx_en = 0;
  logic [1:0] pre_sel = 0;
  logic [2:0] sec_sel = 0;
  logic [NREQ-1:0] dly_req = 0;
  logic osc_en, matrix_clk, periph_clk;

  int compared = 0, mismatched = 0;
  string phase = "R10 reset";

  int m_osc = 0, m_sd = 0, m_pc = 0, m_po = 0, m_pd = 0, m_sc = 0, m_so = 0;
  int ext_div = 0;
  int cnt_per = 0, cnt_mtx = 0, last_per = 0, last_mtx = 0;

  clk_source_ctrl #(.NREQ(NREQ)) uut (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .ext_clk(ext_clk),
    .pwr_down(pwr_down), .pd_en(pd_en), .force_on(force_on),
    .sel_ext(sel_ext), .mtx_en(mtx_en), .pre_sel(pre_sel),
    .sec_sel(sec_sel), .dly_req(dly_req), .osc_en(osc_en),
    .matrix_clk(matrix_clk), .periph_clk(periph_clk)
  );

  always #2.5 clk = ~clk;

  function automatic int sec_ratio(input int s);
    int t[8] = '{1, 2, 3, 4, 8, 12, 24, 64};
    return t[s];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_osc = 0; m_sd = 0; m_pc = 0; m_po = 0; m_pd = 0; m_sc = 0; m_so = 0;
    end else begin
      if (m_osc == 0) begin
        m_sd = 0; m_pc = 0; m_po = 0; m_pd = 0; m_sc = 0; m_so = 0;
      end else begin
        int s, pn, sn, npo;
        s = sel_ext ? int'(ext_clk) : int'(osc_clk);
        pn = 1 << pre_sel;
        sn = sec_ratio(int'(sec_sel));
        npo = m_po;
        if (pn == 1) npo = s;
        else if (s == 1 && m_sd == 0) begin
          m_pc = (m_pc >= pn - 1) ? 0 : m_pc + 1;
          if (m_pc == 0) npo = 1; else if (m_pc == pn / 2) npo = 0;
        end
        m_sd = s;
        if (sn == 1) m_so = m_po;
        else if (m_po == 1 && m_pd == 0) begin
          m_sc = (m_sc >= sn - 1) ? 0 : m_sc + 1;
          if (m_sc == 0) m_so = 1; else if (m_sc == sn / 2) m_so = 0;
        end
        m_pd = m_po;
        m_po = npo;
      end
      m_osc = (pd_en && pwr_down) ? 0 : ((force_on || dly_req != 0) ? 1 : 0);
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic near(input string tag, input int got, input int exp);
    compared++;
    if (got < exp - 1 || got > exp + 1) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d (+/-1)", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compared++;
      if (osc_en !== (m_osc != 0) || periph_clk !== (m_po != 0) ||
          matrix_clk !== (m_so != 0 && mtx_en)) begin
        mismatched++;
        $display("FAIL %s: got en/per/mtx %b%b%b expected %0d%0d%0d at %0t",
                 phase, osc_en, periph_clk, matrix_clk, m_osc, m_po,
                 (m_so != 0 && mtx_en) ? 1 : 0, $time);
      end
      if (periph_clk && last_per == 0) cnt_per++;
      if (matrix_clk && last_mtx == 0) cnt_mtx++;
      last_per = periph_clk; last_mtx = matrix_clk;
      osc_clk = ~osc_clk;
      ext_div++;
      if (ext_div == 3) begin ext_div = 0; ext_clk = ~ext_clk; end
    end
  endtask

  task automatic restart;
    force_on = 0; step(2); force_on = 1; step(4);
    cnt_per = 0; cnt_mtx = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    mismatched++; compared++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    step(3);
    check("R10 reset osc_en", int'(osc_en), 0);
    check("R10 reset periph_clk", int'(periph_clk), 0);
    rst_n = 1;
    phase = "R5 idle"; step(5);
    check("R5 idle osc_en", int'(osc_en), 0);

    phase = "R3 force"; force_on = 1; mtx_en = 1; step(1);
    check("R3 force osc_en", int'(osc_en), 1);
    step(20);

    phase = "R7 pre div4"; pre_sel = 2; restart; step(80);
    near("R7 periph rises div4", cnt_per, 10);
    phase = "R7 pre div8"; pre_sel = 3; restart; step(96);
    near("R7 periph rises div8", cnt_per, 6);

    phase = "R8 sec div3"; pre_sel = 1; sec_sel = 2; restart; step(96);
    near("R8 matrix rises div3", cnt_mtx, 8);
    for (int s = 0; s < 8; s++) begin
      phase = "R8 sec sweep"; pre_sel = 0; sec_sel = 3'(s); restart; step(140);
    end

    phase = "R6 ext"; sel_ext = 1; pre_sel = 0; sec_sel = 3; restart; step(96);
    near("R6 matrix rises ext div4", cnt_mtx, 4);
    sel_ext = 0;

    phase = "R9 gate"; sec_sel = 1; mtx_en = 0; restart; step(40);
    check("R9 matrix held low", cnt_mtx, 0);
    near("R9 periph still runs", cnt_per, 20);
    mtx_en = 1;

    phase = "R1 pd"; pd_en = 1; pwr_down = 1; dly_req = 4'b0011; step(2);
    check("R1 osc_en off", int'(osc_en), 0);
    check("R10 periph off", int'(periph_clk), 0);
    check("R10 matrix off", int'(matrix_clk), 0);
    step(8);

    phase = "R2 ignore"; pd_en = 0; dly_req = 0; step(2);
    check("R2 osc_en on", int'(osc_en), 1);
    step(10);

    phase = "R4 requests"; force_on = 0; pwr_down = 0; step(2);
    check("R5 off without demand", int'(osc_en), 0);
    dly_req[1] = 1; step(1);
    check("R4 wake on req1", int'(osc_en), 1);
    step(10);
    dly_req[3] = 1; step(3);
    dly_req[1] = 0; step(1);
    check("R4 held by req3", int'(osc_en), 1);
    step(5);
    dly_req[3] = 0; step(1);
    check("R4 off after all drop", int'(osc_en), 0);

    phase = "R5 per-edge wake"; step(5);
    dly_req[0] = 1; step(12);
    dly_req[0] = 0; step(1);
    check("R5 sleep between edges", int'(osc_en), 0);
    step(4);
    dly_req[2] = 1; step(1);
    check("R5 wake for next edge", int'(osc_en), 1);
    step(12);
    dly_req = 0; step(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule